// File: doc/BRIEF.md
# Multilevel Ramp-Read Sense Decoder

This block is the digital back end of a two-bit-per-cell read that uses a rising gate ramp instead of fixed sensing references. While the ramp climbs, three reference comparators trip one after another, and one comparator watches the addressed array cell. Each reference trip sets one more bit of a thermometer code, so the code steps 000, 001, 011, 111. The cell's stored value follows from how many references had tripped when the cell's own comparator fired. A cell that trips earlier holds less charge.

A read begins with a start pulse, which raises the ramp-run control. The block passes every trigger through a synchronizer and acts only on the rising edge. Each sense path counts once and is then treated as switched off. When the last reference trips, the read ends. The block then drops the ramp-run control, pulses the ramp reset and issues a one-cycle valid strobe with the decoded two-bit value. If the reference trips break their fixed order, the read ends at once with an error flag and value 00.

Top module: `mlc_ramp_sense`

## Requirements
- R1: While reset is active and after it is released, valid_o, ramp_run_o, ramp_rst_o and err_o are 0 and data_o is 00.
- R2: A start_i pulse while no read is running sets ramp_run_o on the next clock. A start_i pulse during a running read has no effect on that read's result or timing.
- R3: A trigger level applied before clock edge k acts on the state at edge k+2, so its result is visible after edge k+2. A trigger held high acts only once per read.
- R4: The value equals the number of references not yet tripped when the cell trips: none tripped gives 11, ref_trig_i[0] only gives 10, ref_trig_i[1:0] gives 01, and all three or no cell trip gives 00. data_o[1] is the MSB.
- R5: If the cell trigger and one or more reference triggers act in the same cycle, the cell counts as having tripped before those references.
- R6: The action of ref_trig_i[2] ends the read. In that same cycle valid_o and ramp_rst_o are 1 for exactly one cycle and ramp_run_o returns to 0.
- R7: After its first acted-on rise within a read, a further rise of cell_trig_i in that read is ignored.
- R8: A reference set that is not a thermometer code (for example ref_trig_i[1] before ref_trig_i[0]) ends the read with valid_o, err_o = 1 and data_o = 00. err_o returns to 0 when the next read starts.
- R9: Between reads, data_o and err_o hold their last values, and trigger activity causes no valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Read start pulse |
| ref_trig_i | input | NUM_REF | Reference comparator triggers, bit 0 trips first |
| cell_trig_i | input | 1 | Array-cell comparator trigger |
| ramp_run_o | output | 1 | Ramp enable, high while a read runs |
| ramp_rst_o | output | 1 | One-cycle ramp reset at end of read |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | VAL_W | Decoded cell value, MSB first |
| err_o | output | 1 | Reference order error, held until next start |

## Verification
The bench builds the block with its defaults: three references and two synchronizer stages. This gives all four decoded values and a fixed three-edge trigger latency that the bench predicts cycle by cycle. With that setup the table can place the cell trip before, between, with and after each reference trip. It also covers simultaneous reference trips, ordering faults, a repeated cell pulse and a restart during a read.

// File: rtl/mlc_sense_pkg.sv
package mlc_sense_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SENSE = 1'b1
    } sense_state_e;
endpackage

// File: rtl/mlc_trig_sync.sv
// Multi-stage synchronizer with rising-edge detection for a trigger vector.
module mlc_trig_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] trig_i,
    output logic [WIDTH-1:0] rise_o
);
    // pipe_q[0..STAGES-1] synchronize, pipe_q[STAGES] keeps the previous level
    logic [STAGES:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], trig_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/mlc_therm_check.sv
// Reports whether a code is a legal thermometer (ones filled from bit 0).
module mlc_therm_check #(
    parameter int NUM_REF = 3
) (
    input  logic [NUM_REF-1:0] code_i,
    output logic               ordered_o
);
    logic [NUM_REF-1:0] bumped;

    always_comb begin
        bumped    = code_i + 1'b1;
        ordered_o = ((code_i & bumped) == '0);
    end
endmodule

// File: rtl/mlc_level_decode.sv
// Value = number of references still untripped in the captured code.
module mlc_level_decode #(
    parameter int NUM_REF = 3,
    localparam int VAL_W  = $clog2(NUM_REF + 1)
) (
    input  logic [NUM_REF-1:0] code_i,
    output logic [VAL_W-1:0]   value_o
);
    logic [VAL_W-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < NUM_REF; i++) begin
            ones = ones + VAL_W'(code_i[i]);
        end
        value_o = VAL_W'(NUM_REF) - ones;
    end
endmodule

// File: rtl/mlc_ramp_sense.sv
module mlc_ramp_sense
    import mlc_sense_pkg::*;
#(
    parameter int NUM_REF     = 3,
    parameter int SYNC_STAGES = 2,
    localparam int VAL_W      = $clog2(NUM_REF + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [NUM_REF-1:0] ref_trig_i,
    input  logic               cell_trig_i,
    output logic               ramp_run_o,
    output logic               ramp_rst_o,
    output logic               valid_o,
    output logic [VAL_W-1:0]   data_o,
    output logic               err_o
);
    typedef struct packed {
        sense_state_e        state;
        logic [NUM_REF-1:0]  code;
        logic                cell_hit;
        logic [NUM_REF-1:0]  cap;
        logic [VAL_W-1:0]    data;
        logic                err;
        logic                valid;
        logic                ramp_rst;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_REF:0]   rise;
    logic [NUM_REF-1:0] ref_rise;
    logic               cell_rise;
    logic               cell_now;
    logic [NUM_REF-1:0] new_code;
    logic [NUM_REF-1:0] sel_code;
    logic               ordered;
    logic [VAL_W-1:0]   level;

    mlc_trig_sync #(
        .WIDTH  (NUM_REF + 1),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i ({cell_trig_i, ref_trig_i}),
        .rise_o (rise)
    );

    always_comb begin
        ref_rise  = rise[NUM_REF-1:0];
        cell_rise = rise[NUM_REF];
        cell_now  = cell_rise & ~r_q.cell_hit;
        new_code  = r_q.code | ref_rise;
        // a cell trip in the same cycle as references sees the code before them
        if (cell_now)          sel_code = r_q.code;
        else if (r_q.cell_hit) sel_code = r_q.cap;
        else                   sel_code = new_code;
    end

    mlc_therm_check #(.NUM_REF(NUM_REF)) u_check (
        .code_i    (new_code),
        .ordered_o (ordered)
    );

    mlc_level_decode #(.NUM_REF(NUM_REF)) u_decode (
        .code_i  (sel_code),
        .value_o (level)
    );

    always_comb begin
        r_d          = r_q;
        r_d.valid    = 1'b0;
        r_d.ramp_rst = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state    = ST_SENSE;
                    r_d.code     = '0;
                    r_d.cap      = '0;
                    r_d.cell_hit = 1'b0;
                    r_d.err      = 1'b0;
                end
            end
            ST_SENSE: begin
                r_d.code = new_code;
                if (cell_now) begin
                    r_d.cell_hit = 1'b1;
                    r_d.cap      = r_q.code;
                end
                if (!ordered) begin
                    r_d.state    = ST_IDLE;
                    r_d.err      = 1'b1;
                    r_d.data     = '0;
                    r_d.valid    = 1'b1;
                    r_d.ramp_rst = 1'b1;
                end else if (new_code[NUM_REF-1]) begin
                    r_d.state    = ST_IDLE;
                    r_d.data     = level;
                    r_d.valid    = 1'b1;
                    r_d.ramp_rst = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ramp_run_o = (r_q.state == ST_SENSE);
    assign ramp_rst_o = r_q.ramp_rst;
    assign valid_o    = r_q.valid;
    assign data_o     = r_q.data;
    assign err_o      = r_q.err;
endmodule

// File: rtl/mlc_ramp_sense_chk.sv
module mlc_ramp_sense_chk #(
    parameter int VAL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             ramp_run_o,
    input logic             ramp_rst_o,
    input logic             valid_o,
    input logic [VAL_W-1:0] data_o,
    input logic             err_o
);
    p_start_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !ramp_run_o) |=> ramp_run_o);

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_valid_ends_ramp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!ramp_run_o && ramp_rst_o));

    p_valid_after_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(ramp_run_o));

    p_err_zero_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (data_o == '0));

    p_err_only_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> valid_o);

    p_data_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> valid_o);
endmodule

bind mlc_ramp_sense mlc_ramp_sense_chk #(.VAL_W(VAL_W)) u_chk (.*);

// File: tb/mlc_ramp_sense_test.sv
`timescale 1ns/1ps
module mlc_ramp_sense_test;
    localparam int NUM_REF = 3;
    localparam int VAL_W   = 2;
    localparam int NV      = 13;

    typedef struct packed {
        logic [4:0] t1, t2, t3, tc, tc2, rs, fin;
        logic [1:0] data;
        logic       err;
    } vec_t;

    // times are negedge indices after start; 31 = never; fin = cycle the read ends
    localparam vec_t VECS [NV] = '{
        '{5'd2, 5'd4, 5'd6, 5'd1,  5'd31, 5'd0, 5'd6, 2'b11, 1'b0},
        '{5'd2, 5'd4, 5'd6, 5'd3,  5'd31, 5'd0, 5'd6, 2'b10, 1'b0},
        '{5'd2, 5'd4, 5'd6, 5'd5,  5'd31, 5'd4, 5'd6, 2'b01, 1'b0},
        '{5'd2, 5'd4, 5'd6, 5'd31, 5'd31, 5'd0, 5'd6, 2'b00, 1'b0},
        '{5'd2, 5'd4, 5'd6, 5'd7,  5'd31, 5'd0, 5'd6, 2'b00, 1'b0},
        '{5'd2, 5'd4, 5'd6, 5'd2,  5'd31, 5'd0, 5'd6, 2'b11, 1'b0},
        '{5'd2, 5'd4, 5'd6, 5'd4,  5'd31, 5'd0, 5'd6, 2'b10, 1'b0},
        '{5'd2, 5'd4, 5'd6, 5'd6,  5'd31, 5'd0, 5'd6, 2'b01, 1'b0},
        '{5'd5, 5'd3, 5'd7, 5'd1,  5'd31, 5'd0, 5'd3, 2'b00, 1'b1},
        '{5'd4, 5'd5, 5'd2, 5'd1,  5'd31, 5'd0, 5'd2, 2'b00, 1'b1},
        '{5'd3, 5'd3, 5'd6, 5'd4,  5'd31, 5'd0, 5'd6, 2'b01, 1'b0},
        '{5'd3, 5'd3, 5'd3, 5'd2,  5'd31, 5'd0, 5'd3, 2'b11, 1'b0},
        '{5'd2, 5'd4, 5'd6, 5'd1,  5'd5,  5'd0, 5'd6, 2'b11, 1'b0}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic [NUM_REF-1:0] ref_trig_i = '0;
    logic               cell_trig_i = 1'b0;
    logic               ramp_run_o, ramp_rst_o, valid_o, err_o;
    logic [VAL_W-1:0]   data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mlc_ramp_sense #(.NUM_REF(NUM_REF), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_trig_i(ref_trig_i),
        .cell_trig_i(cell_trig_i), .ramp_run_o(ramp_run_o), .ramp_rst_o(ramp_rst_o),
        .valid_o(valid_o), .data_o(data_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int extra;
        logic [1:0] last_data;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk(!valid_o && !ramp_run_o && !ramp_rst_o && !err_o && data_o == 0, "R1 in reset",
            {valid_o, ramp_run_o, ramp_rst_o, err_o, data_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!valid_o && !ramp_run_o && !ramp_rst_o && !err_o && data_o == 0, "R1 after reset",
            {valid_o, ramp_run_o, ramp_rst_o, err_o, data_o}, 0);

        for (int v = 0; v < NV; v++) begin
            extra = 0;
            start_i = 1'b1;              // negedge 0
            for (int n = 1; n <= 12; n++) begin
                @(negedge clk);
                if (n == 1) begin
                    chk(ramp_run_o, "R2 ramp runs after start", ramp_run_o, 1);
                    chk(!err_o, "R8 err cleared by start", err_o, 0);
                end
                if (n == VECS[v].fin + 3) begin
                    chk(valid_o, "R3/R6 valid at expected cycle", valid_o, 1);
                    chk(ramp_rst_o && !ramp_run_o, "R6 ramp reset with valid",
                        {ramp_rst_o, ramp_run_o}, 2);
                    chk(data_o == VECS[v].data, "R4/R5/R7 decoded value", data_o, VECS[v].data);
                    chk(err_o == VECS[v].err, "R8 order error flag", err_o, VECS[v].err);
                end else if (valid_o) begin
                    extra++;
                end
                start_i        = (n == VECS[v].rs);
                ref_trig_i[0]  = (n >= VECS[v].t1);
                ref_trig_i[1]  = (n >= VECS[v].t2);
                ref_trig_i[2]  = (n >= VECS[v].t3);
                cell_trig_i    = (n >= VECS[v].tc && n < VECS[v].tc + 2) || (n >= VECS[v].tc2);
            end
            start_i = 1'b0;
            ref_trig_i = '0;
            cell_trig_i = 1'b0;
            for (int w = 0; w < 6; w++) begin
                @(negedge clk);
                if (valid_o) extra++;
            end
            chk(extra == 0, "R3/R2 no stray valid in vector", extra, 0);
        end

        // R9: trigger activity between reads is ignored, results held
        last_data = data_o;
        extra = 0;
        ref_trig_i = '1;
        cell_trig_i = 1'b1;
        for (int w = 0; w < 10; w++) begin
            @(negedge clk);
            if (valid_o || ramp_run_o) extra++;
        end
        chk(extra == 0, "R9 idle triggers ignored", extra, 0);
        chk(data_o == last_data && !err_o, "R9 result held while idle", data_o, last_data);
        ref_trig_i = '0;
        cell_trig_i = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule